// File: doc/BRIEF.md
# XT-Style Disk Controller Host Register Interface

This block is the byte-wide register face that a host processor sees on an XT-style hard disk controller. There are four register slots. One data port carries both the command block and the transfer data. A status register shows the current phase. A configuration register reports the drive size class, and a control register holds the DMA and interrupt enables. A write to the status slot resets the controller.

The host writes six command bytes through the data port. The block then offers the collected block to a backend with `cmd_valid` and holds it until `cmd_ack`. With the acknowledge, the backend supplies a direction and a byte count. The block then moves that many bytes between the host data port and a backend byte buffer, addressed by `buf_addr`, in the direction given. When the count is reached, it flags completion in status and can interrupt the host. Commands with no data phase complete on the acknowledge itself.

Top module: `xthd_host_if`

## Requirements
- R1: After `rst_n` is released, the status register (slot 1) reads 0x00, and both `irq` and `cmd_valid` are low. Status bits are: bit0 REQUEST, bit1 INPUT, bit2 COMMAND, bit3 SELECT, bit4 INTERRUPT.
- R2: A data-port (slot 0) write while REQUEST is clear and no command awaits the backend enters the command phase. The write stores the byte as command byte 0 and makes status read 0x05. COMMAND and INPUT are never set together.
- R3: The sixth command-phase write raises `cmd_valid`. `cmd_blk` then carries byte i in bits [8i+7:8i], and `cmd_valid` stays high until `cmd_ack` or a controller reset. While the block waits, status reads 0x00.
- R4: On `cmd_ack` with `cmd_dir`=2'b10 and a nonzero `cmd_len`, status becomes 0x02. Each data-port read then returns `buf_rdata` at offsets 0, 1, … in turn.
- R5: A data-port read while INPUT is clear returns the status byte 0x00.
- R6: When the last byte of a transfer moves, status becomes exactly 0x10 (INTERRUPT only).
- R7: `irq` is high exactly when INTERRUPT is set and control bit1 is set. A control (slot 3) write stores the byte, which reads back from slot 3, and clears INTERRUPT.
- R8: On `cmd_ack` with `cmd_dir`=2'b01 and a nonzero `cmd_len`, status becomes 0x01. Each data-port write is then driven on `buf_wdata` with `buf_we` at offsets 0, 1, … in turn.
- R9: On `cmd_ack` with `cmd_dir` of 2'b00 or 2'b11, or with `cmd_len` of 0, status becomes 0x10 at once.
- R10: Data-port writes while `cmd_valid` is high are ignored. They leave `cmd_blk`, status and the buffer unchanged.
- R11: A write to slot 1 aborts any command, drops `cmd_valid`, and leaves status at 0x08 (SELECT only).
- R12: `dma_ok` is high when control bit0 is set, INPUT or REQUEST is set, and COMMAND is clear. Otherwise it is low.
- R13: Slot 2 reads 0 when `drive_size` is at least 42,613,760 bytes, and 2 when it is below that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 1 | Host access strobe, one cycle per access |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 2 | Register slot: 0 data, 1 status/reset, 2 jumper, 3 control |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, combinational on the slot |
| drive_size | input | 32 | Attached drive capacity in bytes |
| irq | output | 1 | Interrupt request to host |
| dma_ok | output | 1 | DMA service permitted |
| cmd_valid | output | 1 | Command block offered to backend |
| cmd_blk | output | 48 | Six command bytes, byte 0 lowest |
| cmd_ack | input | 1 | Backend accepts command |
| cmd_dir | input | 2 | 01 host-to-device, 10 device-to-host, other none |
| cmd_len | input | 16 | Transfer byte count, sampled with `cmd_ack` |
| buf_addr | output | 16 | Backend buffer offset |
| buf_rdata | input | 8 | Buffer byte at `buf_addr` |
| buf_we | output | 1 | Buffer write strobe |
| buf_wdata | output | 8 | Buffer write byte |

## Verification
A wrong offset shows up at the port on the very next data access. An input read returns the buffer byte of the wrong slot, or an output write lands at the wrong `buf_addr`. A wrong phase decision shows in the status register one cycle after the access that caused it. A lost or early completion shows in the same way, and also through `irq`, which the control write must clear in the following cycle. A slip in the six-byte count appears as `cmd_valid` rising one write early or late, with misplaced bytes in `cmd_blk`.

// File: rtl/xthd_pkg.sv
package xthd_pkg;
  // status bit positions
  localparam int ST_REQ = 0;
  localparam int ST_IN  = 1;
  localparam int ST_CMD = 2;
  localparam int ST_SEL = 3;
  localparam int ST_INT = 4;
  localparam int ST_W   = 5;

  // control bit positions
  localparam int CT_DMA = 0;
  localparam int CT_IEN = 1;

  typedef enum logic [1:0] {
    SLOT_DATA = 2'd0,
    SLOT_STAT = 2'd1,
    SLOT_JMP  = 2'd2,
    SLOT_CTRL = 2'd3
  } slot_e;

  // true when the byte at position pos is the final one of len bytes
  function automatic logic beat_is_last(input logic [31:0] pos, input logic [31:0] len);
    return (pos + 32'd1) >= len;
  endfunction

  // size class code reported in the jumper slot
  function automatic logic [7:0] size_code(input logic [31:0] bytes, input logic [31:0] big);
    return (bytes >= big) ? 8'd0 : 8'd2;
  endfunction
endpackage

// File: rtl/xthd_cmd_store.sv
module xthd_cmd_store #(
  parameter int CMD_LEN = 6,
  localparam int IDX_W = $clog2(CMD_LEN)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [IDX_W-1:0]       idx,
  input  logic [7:0]             wdata,
  output logic [8*CMD_LEN-1:0]   blk
);
  for (genvar g = 0; g < CMD_LEN; g++) begin : g_byte
    always_ff @(posedge clk) begin
      if (!rst_n)
        blk[8*g +: 8] <= '0;
      else if (we && idx == IDX_W'(g))
        blk[8*g +: 8] <= wdata;
    end
  end
endmodule

// File: rtl/xthd_cfg.sv
module xthd_cfg #(
  parameter logic [31:0] BIG_BYTES = 32'd42613760
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_ctl,
  input  logic [7:0]  wdata,
  input  logic [31:0] drive_size,
  output logic [7:0]  ctrl,
  output logic [7:0]  jumper
);
  import xthd_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n)      ctrl <= '0;
    else if (wr_ctl) ctrl <= wdata;
  end

  assign jumper = size_code(drive_size, BIG_BYTES);
endmodule

// File: rtl/xthd_seq.sv
module xthd_seq #(
  parameter int LEN_W   = 16,
  parameter int CMD_LEN = 6,
  localparam int IDX_W  = $clog2(CMD_LEN)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_data,
  input  logic                 rd_data,
  input  logic                 wr_rst,
  input  logic                 wr_ctl,
  input  logic                 be_ack,
  input  logic [1:0]           be_dir,
  input  logic [LEN_W-1:0]     be_len,
  output logic [4:0]           status,
  output logic [LEN_W-1:0]     offset,
  output logic                 waiting,
  output logic [IDX_W-1:0]     cmd_idx,
  output logic                 ev_cmd_byte,
  output logic                 ev_buf_wr,
  output logic                 ev_done
);
  import xthd_pkg::*;

  logic [LEN_W-1:0] xfer_len;
  logic ev_in_rd, ev_dispatch, ack_seen, ack_nodata, last_beat;

  assign ev_cmd_byte = wr_data && !waiting && (!status[ST_REQ] || status[ST_CMD]);
  assign ev_buf_wr   = wr_data && !waiting && status[ST_REQ] && !status[ST_CMD];
  assign ev_in_rd    = rd_data && status[ST_IN];
  assign cmd_idx     = status[ST_REQ] ? offset[IDX_W-1:0] : '0;
  assign ev_dispatch = ev_cmd_byte && status[ST_REQ] && status[ST_CMD] &&
                       (offset == LEN_W'(CMD_LEN - 1));
  assign ack_seen    = be_ack && waiting;
  assign ack_nodata  = (be_dir == 2'b00) || (be_dir == 2'b11) || (be_len == '0);
  assign last_beat   = beat_is_last(32'(offset), 32'(xfer_len));
  assign ev_done     = ((ev_buf_wr || ev_in_rd) && last_beat) || (ack_seen && ack_nodata);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status   <= '0;
      offset   <= '0;
      xfer_len <= '0;
      waiting  <= 1'b0;
    end else if (wr_rst) begin
      status   <= 5'(1 << ST_SEL);
      offset   <= '0;
      xfer_len <= '0;
      waiting  <= 1'b0;
    end else begin
      if (wr_ctl) status[ST_INT] <= 1'b0;
      if (ev_done) begin
        status   <= 5'(1 << ST_INT);
        offset   <= '0;
        xfer_len <= '0;
        waiting  <= 1'b0;
      end else if (ev_dispatch) begin
        status  <= '0;
        offset  <= '0;
        waiting <= 1'b1;
      end else if (ev_cmd_byte) begin
        status <= 5'((1 << ST_CMD) | (1 << ST_REQ));
        offset <= status[ST_REQ] ? offset + 1'b1 : LEN_W'(1);
      end else if (ev_buf_wr || ev_in_rd) begin
        offset <= offset + 1'b1;
      end else if (ack_seen) begin
        waiting  <= 1'b0;
        xfer_len <= be_len;
        status   <= (be_dir == 2'b01) ? 5'(1 << ST_REQ) : 5'(1 << ST_IN);
      end
    end
  end
endmodule

// File: rtl/xthd_host_if.sv
module xthd_host_if #(
  parameter int          LEN_W     = 16,
  parameter int          CMD_LEN   = 6,
  parameter logic [31:0] BIG_BYTES = 32'd42613760,
  localparam int         IDX_W     = $clog2(CMD_LEN)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 host_sel,
  input  logic                 host_we,
  input  logic [1:0]           host_addr,
  input  logic [7:0]           host_wdata,
  output logic [7:0]           host_rdata,
  input  logic [31:0]          drive_size,
  output logic                 irq,
  output logic                 dma_ok,
  output logic                 cmd_valid,
  output logic [8*CMD_LEN-1:0] cmd_blk,
  input  logic                 cmd_ack,
  input  logic [1:0]           cmd_dir,
  input  logic [LEN_W-1:0]     cmd_len,
  output logic [LEN_W-1:0]     buf_addr,
  input  logic [7:0]           buf_rdata,
  output logic                 buf_we,
  output logic [7:0]           buf_wdata
);
  import xthd_pkg::*;

  logic wr_data, rd_data, wr_rst, wr_ctl;
  logic [4:0] status;
  logic [LEN_W-1:0] offset;
  logic waiting, ev_cmd_byte, ev_buf_wr, ev_done;
  logic [IDX_W-1:0] cmd_idx;
  logic [7:0] ctrl, jumper;

  assign wr_data = host_sel &&  host_we && host_addr == SLOT_DATA;
  assign rd_data = host_sel && !host_we && host_addr == SLOT_DATA;
  assign wr_rst  = host_sel &&  host_we && host_addr == SLOT_STAT;
  assign wr_ctl  = host_sel &&  host_we && host_addr == SLOT_CTRL;

  xthd_seq #(.LEN_W(LEN_W), .CMD_LEN(CMD_LEN)) seq_i (
    .clk, .rst_n, .wr_data, .rd_data, .wr_rst, .wr_ctl,
    .be_ack(cmd_ack), .be_dir(cmd_dir), .be_len(cmd_len),
    .status, .offset, .waiting, .cmd_idx,
    .ev_cmd_byte, .ev_buf_wr, .ev_done
  );

  xthd_cmd_store #(.CMD_LEN(CMD_LEN)) store_i (
    .clk, .rst_n, .we(ev_cmd_byte), .idx(cmd_idx), .wdata(host_wdata), .blk(cmd_blk)
  );

  xthd_cfg #(.BIG_BYTES(BIG_BYTES)) cfg_i (
    .clk, .rst_n, .wr_ctl, .wdata(host_wdata), .drive_size, .ctrl, .jumper
  );

  assign cmd_valid = waiting;
  assign buf_addr  = offset;
  assign buf_we    = ev_buf_wr;
  assign buf_wdata = host_wdata;
  assign irq       = status[ST_INT] && ctrl[CT_IEN];
  assign dma_ok    = ctrl[CT_DMA] && (status[ST_IN] || status[ST_REQ]) && !status[ST_CMD];

  always_comb begin
    unique case (slot_e'(host_addr))
      SLOT_DATA: host_rdata = status[ST_IN] ? buf_rdata : 8'h00;
      SLOT_STAT: host_rdata = {3'b000, status};
      SLOT_JMP:  host_rdata = jumper;
      SLOT_CTRL: host_rdata = ctrl;
      default:   host_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/xthd_host_if_chk.sv
module xthd_host_if_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       host_sel,
  input logic       host_we,
  input logic [1:0] host_addr,
  input logic [4:0] status,
  input logic       cmd_valid,
  input logic       cmd_ack,
  input logic       irq,
  input logic       buf_we,
  input logic       ev_done
);
  import xthd_pkg::*;

  logic rst_wr, ctl_wr;
  assign rst_wr = host_sel && host_we && host_addr == SLOT_STAT;
  assign ctl_wr = host_sel && host_we && host_addr == SLOT_CTRL;

  // R2
  phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(status[ST_CMD] && status[ST_IN]));

  // R3
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ack && !rst_wr) |=> cmd_valid);

  // R6
  done_int_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_done && !rst_wr) |=> (status == 5'(1 << ST_INT)));

  // R7
  ctl_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !cmd_ack) |=> !irq);

  // R10
  no_buf_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> !cmd_valid);

  // R11
  rst_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_wr |=> (status == 5'(1 << ST_SEL) && !cmd_valid));
endmodule

bind xthd_host_if xthd_host_if_chk chk_i (
  .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_we(host_we),
  .host_addr(host_addr), .status(status), .cmd_valid(cmd_valid),
  .cmd_ack(cmd_ack), .irq(irq), .buf_we(buf_we), .ev_done(ev_done)
);

// File: tb/xthd_host_if_tb.sv
module xthd_host_if_tb_top;
  localparam int PERIOD = 10;
  localparam logic [31:0] BIG = 32'd42613760;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_sel = 1'b0, host_we = 1'b0;
  logic [1:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic [31:0] drive_size = 32'd1000;
  logic irq, dma_ok, cmd_valid, cmd_ack = 1'b0, buf_we;
  logic [47:0] cmd_blk;
  logic [1:0] cmd_dir = '0;
  logic [15:0] cmd_len = '0, buf_addr;
  logic [7:0] buf_rdata, buf_wdata;
  logic [7:0] mem [0:15];
  int total = 0, bad = 0;

  always #(PERIOD/2) clk = ~clk;

  xthd_host_if dut_i (
    .clk, .rst_n, .host_sel, .host_we, .host_addr, .host_wdata, .host_rdata,
    .drive_size, .irq, .dma_ok, .cmd_valid, .cmd_blk, .cmd_ack, .cmd_dir,
    .cmd_len, .buf_addr, .buf_rdata, .buf_we, .buf_wdata
  );

  assign buf_rdata = mem[buf_addr[3:0]];
  always @(posedge clk) if (buf_we) mem[buf_addr[3:0]] <= buf_wdata;

  task automatic chk(input string tag, input logic [47:0] act, input logic [47:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    host_sel = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d;
    @(posedge clk); #1;
    host_sel = 1'b0; host_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    host_sel = 1'b1; host_we = 1'b0; host_addr = a;
    #1 d = host_rdata;
    @(posedge clk); #1;
    host_sel = 1'b0;
  endtask

  task automatic send_cmd(input logic [7:0] base);
    for (int i = 0; i < 6; i++) bus_wr(2'd0, base + 8'(i));
    chk("R3 cmd_valid", 48'(cmd_valid), 48'd1);
    chk("R3 cmd_blk", cmd_blk, {base+8'd5, base+8'd4, base+8'd3, base+8'd2, base+8'd1, base});
  endtask

  task automatic ack(input logic [1:0] dir, input logic [15:0] len);
    @(negedge clk);
    cmd_ack = 1'b1; cmd_dir = dir; cmd_len = len;
    @(posedge clk); #1;
    cmd_ack = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    bus_rd(2'd1, v);
    chk("R1 status", 48'(v), 48'h00);
    chk("R1 irq", 48'(irq), 48'd0);
    chk("R1 cmd_valid", 48'(cmd_valid), 48'd0);
  endtask

  task automatic t_jumper();
    logic [7:0] v;
    drive_size = BIG - 1; bus_rd(2'd2, v); chk("R13 small", 48'(v), 48'd2);
    drive_size = BIG;     bus_rd(2'd2, v); chk("R13 at limit", 48'(v), 48'd0);
    drive_size = 32'd80000000; bus_rd(2'd2, v); chk("R13 large", 48'(v), 48'd0);
  endtask

  task automatic t_entry();
    logic [7:0] v;
    bus_wr(2'd0, 8'h77);
    bus_rd(2'd1, v);
    chk("R2 status", 48'(v), 48'h05);
    bus_wr(2'd1, 8'h00);
    bus_rd(2'd1, v);
    chk("R11 abort", 48'(v), 48'h08);
  endtask

  task automatic t_read();
    logic [7:0] v;
    for (int i = 0; i < 16; i++) mem[i] = 8'hA0 + 8'(i);
    send_cmd(8'h10);
    bus_rd(2'd1, v); chk("R3 wait status", 48'(v), 48'h00);
    bus_wr(2'd0, 8'hEE);
    chk("R10 blk kept", cmd_blk, {8'h15, 8'h14, 8'h13, 8'h12, 8'h11, 8'h10});
    bus_rd(2'd1, v); chk("R10 status kept", 48'(v), 48'h00);
    ack(2'b10, 16'd3);
    bus_rd(2'd1, v); chk("R4 input status", 48'(v), 48'h02);
    for (int i = 0; i < 3; i++) begin
      bus_rd(2'd0, v); chk("R4 data", 48'(v), 48'(8'hA0 + 8'(i)));
    end
    bus_rd(2'd1, v); chk("R6 done status", 48'(v), 48'h10);
    chk("R7 irq masked", 48'(irq), 48'd0);
    bus_rd(2'd0, v); chk("R5 status byte", 48'(v), 48'h00);
  endtask

  task automatic t_irq();
    logic [7:0] v;
    bus_wr(2'd3, 8'h02);
    bus_rd(2'd3, v); chk("R7 ctrl readback", 48'(v), 48'h02);
    send_cmd(8'h40);
    ack(2'b00, 16'd5);
    bus_rd(2'd1, v); chk("R9 nodata status", 48'(v), 48'h10);
    chk("R7 irq raised", 48'(irq), 48'd1);
    bus_wr(2'd3, 8'h02);
    chk("R7 irq cleared", 48'(irq), 48'd0);
    bus_rd(2'd1, v); chk("R7 int cleared", 48'(v), 48'h00);
  endtask

  task automatic t_write();
    logic [7:0] v;
    send_cmd(8'h20);
    ack(2'b01, 16'd2);
    bus_rd(2'd1, v); chk("R8 out status", 48'(v), 48'h01);
    bus_wr(2'd0, 8'h5A);
    bus_rd(2'd1, v); chk("R8 mid status", 48'(v), 48'h01);
    bus_wr(2'd0, 8'hC3);
    chk("R8 mem0", 48'(mem[0]), 48'h5A);
    chk("R8 mem1", 48'(mem[1]), 48'hC3);
    chk("R8 mem2 untouched", 48'(mem[2]), 48'hA2);
    bus_rd(2'd1, v); chk("R6 out done", 48'(v), 48'h10);
  endtask

  task automatic t_zero();
    logic [7:0] v;
    send_cmd(8'h30);
    ack(2'b10, 16'd0);
    bus_rd(2'd1, v); chk("R9 zero len", 48'(v), 48'h10);
  endtask

  task automatic t_dma();
    logic [7:0] v;
    bus_wr(2'd3, 8'h01);
    bus_wr(2'd0, 8'h50);
    chk("R12 cmd phase", 48'(dma_ok), 48'd0);
    for (int i = 1; i < 6; i++) bus_wr(2'd0, 8'h50 + 8'(i));
    ack(2'b10, 16'd1);
    chk("R12 input phase", 48'(dma_ok), 48'd1);
    bus_rd(2'd0, v);
    chk("R12 after done", 48'(dma_ok), 48'd0);
  endtask

  task automatic t_rst_wait();
    logic [7:0] v;
    send_cmd(8'h60);
    bus_wr(2'd1, 8'h00);
    chk("R11 valid dropped", 48'(cmd_valid), 48'd0);
    bus_rd(2'd1, v); chk("R11 select", 48'(v), 48'h08);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 8'h00;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_jumper();
    t_entry();
    t_read();
    t_irq();
    t_write();
    t_zero();
    t_dma();
    t_rst_wait();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule